// File: doc/BRIEF.md
# Flyback Charge Control Sequencer

This block is the digital sequencer of a capacitor-charging flyback converter. It turns a small set of comparator flags and control pins into one switch gate command and an active-low completion flag. A charge run begins only on a rising edge of the enable pin that arrives while the supply-valid flag is true. The switch stays off until the current-limit setup window reports that it has ended. After that the block alternates on-phases and off-phases until the output-trip comparator reports that the target voltage has been reached.

Each on-phase ends when the peak-current flag rises, or at a maximum length counted in clock cycles, whichever comes first. A mode input from a low-output comparator selects how each off-phase ends. In soft-start (timer) mode the off-phase has a fixed length. In fast mode the next on-phase begins at the valley indication, and a timeout fires if no valley indication arrives. An open-secondary fault latches the switch off and pulls the completion flag low.

The finished state and the fault state are left only by pulling enable low. This returns the block to standby, and a new rising edge is then needed to charge again. Timing is in cycles of a 10 MHz clock, so 13 µs is 130 cycles; every limit is a parameter.

Top module: `chg_sequencer`

## Requirements
- R1: A rising edge on `en_i` seen while `uv_ok_i` is 1 moves the block from standby into the setup wait. The gate is on from the cycle after `setup_done_i` is seen high in that wait.
- R2: A rising edge on `en_i` while `uv_ok_i` is 0 starts nothing. Holding `en_i` high after `uv_ok_i` returns to 1 also starts nothing; a new low-to-high transition of `en_i` is required.
- R3: `en_i` low forces standby in the next cycle from any state: `gate_o` is 0 and `done_n_o` is 1.
- R4: `trip_i` high during an off-phase stops switching. From the next cycle the block stays in the finished state, with `gate_o` 0, until `en_i` goes low.
- R5: `done_n_o` is 0 only in the finished or fault state, both of which exist only while `en_i` is high. It is 1 during setup, during charging and in standby.
- R6: An on-phase ends in the cycle after `ipk_i` is seen high. Without `ipk_i`, `gate_o` stays high for exactly ON_MAX_CYC cycles (default 130).
- R7: With `low_vout_i` = 1 (timer mode), an off-phase lasts exactly OFF_TMR_CYC cycles (default 130), and `valley_i` has no effect on it.
- R8: With `low_vout_i` = 0 (fast mode), the next on-phase starts in the cycle after `valley_i` is seen high in an off-phase. With no valley indication, it starts after FAST_TMO_CYC cycles (default 130).
- R9: `open_sec_i` high during setup, on-phase or off-phase forces `gate_o` to 0 and `done_n_o` to 0 from the next cycle. This state is held until `en_i` goes low.
- R10: `gate_o` stays 0 for as long as the setup wait has not seen `setup_done_i` high.
- R11: While `rst_n` is low and after reset, the block is in standby with `gate_o` 0 and `done_n_o` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (10 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Charge enable; its rising edge starts a run, low means standby |
| uv_ok_i | input | 1 | Supply above the undervoltage level |
| trip_i | input | 1 | Output-trip comparator: target voltage reached |
| valley_i | input | 1 | Valley / dV-dt detect on the switch node |
| ipk_i | input | 1 | Switch current has reached the peak limit |
| open_sec_i | input | 1 | Open secondary winding or diode detected |
| setup_done_i | input | 1 | Current-limit setup window has ended |
| low_vout_i | input | 1 | Output is low: 1 selects timer mode, 0 selects fast mode |
| gate_o | output | 1 | Switch gate command, 1 = on |
| done_n_o | output | 1 | Active-low completion/fault flag |

## Verification
The situations hardest to reach from the ports are the three full-length timer expiries. These are an on-phase that ends without any peak-current indication, a timer-mode off-phase held while the valley flag stays asserted throughout, and a fast-mode off-phase that times out because no valley arrives. To reach them, the stimulus holds the relevant flag steady for a whole window and measures the length of each gate level in cycles, so a count that is off by one shows up directly. Qualification of the enable edge is another corner: the bench raises enable while the supply is invalid, restores the supply with enable still high, and only then toggles enable.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_ON    = 3'd2,
    ST_OFF   = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } chg_st_e;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/chg_start_qual.sv
module chg_start_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic uv_ok_i,
  output logic start_o
);

  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  // qualified low-to-high transition of enable
  assign start_o = en_i & ~en_q & uv_ok_i;

endmodule

// File: rtl/chg_cycle_timer.sv
module chg_cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_o <= '0;
    else if (restart_i)      cnt_o <= '0;
    else if (cnt_o != TOP)   cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
#(
  parameter int unsigned ON_MAX_CYC  = 130,
  parameter int unsigned OFF_TMR_CYC = 130,
  parameter int unsigned FAST_TMO_CYC = 130,
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         start_i,
  input  logic         trip_i,
  input  logic         valley_i,
  input  logic         ipk_i,
  input  logic         open_sec_i,
  input  logic         setup_done_i,
  input  logic         low_vout_i,
  input  logic [W-1:0] cnt_i,
  output chg_st_e      st_o,
  output logic         restart_o
);

  localparam logic [W-1:0] ON_LAST   = W'(ON_MAX_CYC - 1);
  localparam logic [W-1:0] TMR_LAST  = W'(OFF_TMR_CYC - 1);
  localparam logic [W-1:0] FAST_LAST = W'(FAST_TMO_CYC - 1);

  chg_st_e st_q, st_d;
  logic on_exp, tmr_exp, fast_exp, off_end;

  assign on_exp   = (cnt_i == ON_LAST);
  assign tmr_exp  = (cnt_i == TMR_LAST);
  assign fast_exp = (cnt_i == FAST_LAST);
  assign off_end  = low_vout_i ? tmr_exp : (valley_i | fast_exp);

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start_i) st_d = ST_ARM;
        ST_ARM: begin
          if (open_sec_i)        st_d = ST_FAULT;
          else if (setup_done_i) st_d = ST_ON;
        end
        ST_ON: begin
          if (open_sec_i)           st_d = ST_FAULT;
          else if (ipk_i || on_exp) st_d = ST_OFF;
        end
        ST_OFF: begin
          if (open_sec_i)   st_d = ST_FAULT;
          else if (trip_i)  st_d = ST_DONE;
          else if (off_end) st_d = ST_ON;
        end
        ST_DONE:  st_d = ST_DONE;
        ST_FAULT: st_d = ST_FAULT;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign restart_o = (st_d != st_q);
  assign st_o      = st_q;

endmodule

// File: rtl/chg_sequencer.sv
module chg_sequencer
  import chg_pkg::*;
#(
  parameter int unsigned ON_MAX_CYC   = 130,
  parameter int unsigned OFF_TMR_CYC  = 130,
  parameter int unsigned FAST_TMO_CYC = 130
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic uv_ok_i,
  input  logic trip_i,
  input  logic valley_i,
  input  logic ipk_i,
  input  logic open_sec_i,
  input  logic setup_done_i,
  input  logic low_vout_i,
  output logic gate_o,
  output logic done_n_o
);

  localparam int unsigned LONGEST = max3(ON_MAX_CYC, OFF_TMR_CYC, FAST_TMO_CYC);
  localparam int unsigned CW      = $clog2(LONGEST) + 1;

  logic          start;
  logic          restart;
  logic [CW-1:0] cnt;
  chg_st_e       st_q;

  chg_start_qual u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .uv_ok_i (uv_ok_i),
    .start_o (start)
  );

  chg_cycle_timer #(.W(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .cnt_o     (cnt)
  );

  chg_fsm #(
    .ON_MAX_CYC   (ON_MAX_CYC),
    .OFF_TMR_CYC  (OFF_TMR_CYC),
    .FAST_TMO_CYC (FAST_TMO_CYC),
    .W            (CW)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .start_i      (start),
    .trip_i       (trip_i),
    .valley_i     (valley_i),
    .ipk_i        (ipk_i),
    .open_sec_i   (open_sec_i),
    .setup_done_i (setup_done_i),
    .low_vout_i   (low_vout_i),
    .cnt_i        (cnt),
    .st_o         (st_q),
    .restart_o    (restart)
  );

  assign gate_o   = (st_q == ST_ON);
  assign done_n_o = ~((st_q == ST_DONE) | (st_q == ST_FAULT));

endmodule

// File: rtl/chg_sequencer_chk.sv
module chg_sequencer_chk
  import chg_pkg::*;
#(
  parameter int unsigned ON_MAX_CYC = 130
) (
  input logic    clk,
  input logic    rst_n,
  input logic    en_i,
  input logic    uv_ok_i,
  input logic    trip_i,
  input logic    open_sec_i,
  input logic    setup_done_i,
  input logic    gate_o,
  input logic    done_n_o,
  input chg_st_e st
);

  localparam int unsigned RW = $clog2(ON_MAX_CYC + 2) + 1;
  logic [RW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run <= '0;
    else if (gate_o) hi_run <= (hi_run == {RW{1'b1}}) ? hi_run : hi_run + 1'b1;
    else             hi_run <= '0;
  end

  p_no_edge_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !uv_ok_i) |=> (st == ST_IDLE));

  p_standby_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !gate_o);

  p_trip_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && trip_i && en_i && !open_sec_i) |=> (!gate_o && !done_n_o));

  p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> done_n_o);

  p_on_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= RW'(ON_MAX_CYC));

  p_fault_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && open_sec_i && en_i) |=> (!gate_o && !done_n_o));

  p_setup_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARM && !setup_done_i) |=> !gate_o);

endmodule

bind chg_sequencer chg_sequencer_chk #(.ON_MAX_CYC(ON_MAX_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .uv_ok_i      (uv_ok_i),
  .trip_i       (trip_i),
  .open_sec_i   (open_sec_i),
  .setup_done_i (setup_done_i),
  .gate_o       (gate_o),
  .done_n_o     (done_n_o),
  .st           (st_q)
);

// File: tb/chg_sequencer_bench.sv
module chg_sequencer_bench;

  localparam int NV = 21;
  localparam int T_ON = 130;
  localparam int T_TMR = 130;
  localparam int T_FAST = 130;

  // bits: en uv trip valley ipk open setup lowv | exp_gate exp_done_n
  localparam logic [9:0] VEC [NV] = '{
    10'b01_000000_01,  // standby
    10'b11_000000_01,  // edge -> setup wait
    10'b11_000000_01,  // setup not done
    10'b11_000010_11,  // setup done -> on
    10'b11_001010_01,  // peak -> off
    10'b11_010010_11,  // fast mode valley -> on
    10'b11_001010_01,  // peak -> off
    10'b11_100010_00,  // trip -> done
    10'b11_010010_00,  // done held
    10'b01_000000_01,  // enable low
    10'b10_000010_01,  // edge while supply invalid
    10'b11_000010_01,  // supply back, no edge
    10'b01_000000_01,  // enable low
    10'b11_000010_01,  // edge -> setup wait
    10'b11_000010_11,  // on
    10'b11_000110_00,  // open secondary
    10'b11_000010_00,  // fault held
    10'b01_000000_01,  // release
    10'b11_000010_01,  // edge -> setup wait
    10'b11_000010_11,  // on
    10'b01_000010_01   // enable low from on
  };
  localparam string TAG [NV] = '{
    "R11", "R1", "R10", "R1", "R6", "R8", "R6", "R4", "R5", "R3", "R2",
    "R2", "R3", "R1", "R10", "R9", "R9", "R5", "R1", "R10", "R3"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, uv_ok_i = 0, trip_i = 0, valley_i = 0, ipk_i = 0;
  logic open_sec_i = 0, setup_done_i = 0, low_vout_i = 0;
  logic gate_o, done_n_o;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  chg_sequencer u_chg_sequencer (
    .clk (clk), .rst_n (rst_n), .en_i (en_i), .uv_ok_i (uv_ok_i),
    .trip_i (trip_i), .valley_i (valley_i), .ipk_i (ipk_i),
    .open_sec_i (open_sec_i), .setup_done_i (setup_done_i),
    .low_vout_i (low_vout_i), .gate_o (gate_o), .done_n_o (done_n_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic eg, input logic ed);
    n_chk++;
    if (gate_o !== eg || done_n_o !== ed) begin
      n_err++;
      $display("FAIL %s: gate=%b done_n=%b expected gate=%b done_n=%b",
               tag, gate_o, done_n_o, eg, ed);
    end
  endtask

  task automatic chk_n(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R11", 1'b0, 1'b1);
    rst_n = 1'b1;
    step();
    chk("R11", 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      {en_i, uv_ok_i, trip_i, valley_i, ipk_i, open_sec_i, setup_done_i, low_vout_i}
        = VEC[i][9:2];
      step();
      chk(TAG[i], VEC[i][1], VEC[i][0]);
    end

    // R6 full on-phase, R7 timer-mode off-phase with valley held high
    {trip_i, ipk_i, open_sec_i} = '0;
    uv_ok_i = 1; setup_done_i = 1; low_vout_i = 1; valley_i = 1; en_i = 1;
    step();
    step();
    chk("R1", 1'b1, 1'b1);
    n = 0;
    while (gate_o && n < 1000) begin n++; step(); end
    chk_n("R6", n, T_ON);
    n = 0;
    while (!gate_o && n < 1000) begin n++; step(); end
    chk_n("R7", n, T_TMR);

    // R8 fast-mode timeout with no valley
    ipk_i = 1;
    step();
    ipk_i = 0; low_vout_i = 0; valley_i = 0;
    n = 0;
    while (!gate_o && n < 1000) begin n++; step(); end
    chk_n("R8", n, T_FAST);

    // R8 valley after a few cycles
    ipk_i = 1;
    step();
    ipk_i = 0;
    repeat (5) step();
    chk("R8", 1'b0, 1'b1);
    valley_i = 1;
    step();
    chk("R8", 1'b1, 1'b1);
    valley_i = 0;

    en_i = 0;
    step();
    chk("R3", 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule